// File: doc/BRIEF.md
# Multi-Cycle Bus Processor with Load, Store and Conditional Move

This block is a 16-bit processor that runs one instruction over several clock cycles. Eight general registers share one internal bus with an adder/subtractor and its result register. The highest register doubles as the program counter, so the processor fetches its own instructions. It presents an address register on `mem_addr` and reads each instruction word back on `mem_rdata`.

Beyond register moves, immediate loads, addition and subtraction, the processor can read a data word from any address (load). It can write a register to any address through the `mem_wdata` register and the single-cycle `mem_we` strobe (store). It can also copy a register only when the last arithmetic result was nonzero (conditional move). A move into the program counter is a jump. A move out of it captures a loop-back address.

The memory side is a fixed-latency interface without valid/ready. The attached synchronous RAM registers its inputs on a clock edge. The processor samples `mem_rdata` one cycle after that edge and never stalls on back-pressure. The asynchronous `run_async` level is synchronized before use.

Top module: `mc_bus_cpu`

## Requirements
- R1: While `rst_n` is low, the program counter and all registers are zero, and `mem_addr`, `mem_wdata`, `mem_we` and `instr_done` are 0. After reset, fetching starts at address 0.
- R2: `run_async` passes through a two-flop synchronizer. While the synchronized level is low at an instruction boundary, no fetch starts: `mem_addr` holds, and `instr_done` and `mem_we` stay 0.
- R3: Each instruction starts by loading the program counter into `mem_addr` and incrementing the counter. After a one-cycle wait, the word on `mem_rdata` is captured as the instruction. The instruction occupies bits [8:0]: opcode in [8:6], destination X in [5:3], source Y in [2:0]. Opcodes are 0 move, 1 move-immediate, 2 add, 3 subtract, 4 load, 5 store, 6 conditional move, and 7 a no-op.
- R4: Move-immediate reads the word after the instruction as its data, using the same wait step, and advances the program counter a second time.
- R5: Add and subtract compute X+Y or X−Y. The result goes into both register X and the result register G.
- R6: Load drives register Y onto `mem_addr` and, after the wait step, writes the returned word into register X.
- R7: Store drives register Y onto `mem_addr` and register X onto `mem_wdata`. It then raises `mem_we` for exactly one cycle, with both values stable. `mem_we` is 0 at all other times.
- R8: Conditional move copies Y into X when G is nonzero. When G is zero, no register changes.
- R9: A move or move-immediate with destination 7 loads the program counter, so the next fetch uses that address. A move with source 7 copies the address of the next instruction.
- R10: `instr_done` is high for one cycle, in the last cycle of every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_async | input | 1 | Asynchronous run enable level |
| mem_rdata | input | 16 | Instruction or data word from memory |
| mem_addr | output | 16 | Registered memory address |
| mem_wdata | output | 16 | Registered store data |
| mem_we | output | 1 | Registered write strobe, one cycle per store |
| instr_done | output | 1 | One-cycle pulse in the last cycle of each instruction |

## Verification
Register contents are visible only through what the processor writes to memory. The bench therefore runs a program whose stores dump each result to distinct addresses, prefilled with a marker value. A wrong register, a wrong result in G or a misjudged wait step shows up at the next store: a wrong `mem_wdata` value, a marker left in place, or a store landing at the wrong address. Jumps that are not taken, or wrongly taken, show up as skipped guard stores firing or as a lost fetch loop. A strobe lasting more than one cycle is visible on `mem_we` in the very next cycle.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  typedef enum logic [3:0] {
    S_FETCH, S_FWAIT, S_DECODE, S_EXEC, S_ALU1, S_ALU2,
    S_MEMW1, S_MEMW2, S_ST1, S_STW
  } state_t;

  typedef enum logic [2:0] {
    OP_MV, OP_MVI, OP_ADD, OP_SUB, OP_LD, OP_ST, OP_MVNZ, OP_NOP
  } opcode_t;

  typedef enum logic [1:0] {BUS_REG, BUS_G, BUS_DIN} bus_sel_t;

  typedef struct packed {
    bus_sel_t   bsel;
    logic [2:0] bsrc;
    logic       reg_we;
    logic [2:0] reg_dst;
    logic       pc_inc;
    logic       a_ld;
    logic       g_ld;
    logic       sub;
    logic       addr_ld;
    logic       dout_ld;
    logic       w_set;
    logic       ir_ld;
    logic       done;
  } ctrl_t;
endpackage

// File: rtl/bus_run_sync.sv
module bus_run_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d_async;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bus_regfile.sv
module bus_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [W-1:0]            bus_in,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic                    pc_inc,
  input  logic [$clog2(NREG)-1:0] rsel,
  output logic [W-1:0]            rdata
);
  localparam int AW     = $clog2(NREG);
  localparam int PC_IDX = NREG - 1;

  logic [W-1:0] regs [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [W-1:0] q;
      logic         hit;
      assign hit = we && (dst == AW'(i));
      if (i == PC_IDX) begin : g_pc
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      q <= '0;
          else if (hit)    q <= bus_in;
          else if (pc_inc) q <= q + 1'b1;
        end
      end else begin : g_gp
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= '0;
          else if (hit) q <= bus_in;
        end
      end
      assign regs[i] = q;
    end
  endgenerate

  assign rdata = regs[rsel];
endmodule

// File: rtl/bus_alu.sv
module bus_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         a_ld,
  input  logic         g_ld,
  input  logic         sub,
  output logic [W-1:0] g_q
);
  logic [W-1:0] a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      g_q <= '0;
    end else begin
      if (a_ld) a_q <= bus_in;
      if (g_ld) g_q <= sub ? (a_q - bus_in) : (a_q + bus_in);
    end
  end
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_s,
  input  logic [W-1:0] din,
  input  logic         g_nz,
  output ctrl_t        c
);
  state_t     state, nxt;
  logic [8:0] ir;
  opcode_t    op;
  logic [2:0] rx, ry;

  assign op = opcode_t'(ir[8:6]);
  assign rx = ir[5:3];
  assign ry = ir[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      ir    <= '0;
    end else begin
      state <= nxt;
      if (c.ir_ld) ir <= din[8:0];
    end
  end

  always_comb begin
    c         = '0;
    c.bsel    = BUS_REG;
    c.reg_dst = rx;
    nxt       = state;
    unique case (state)
      S_FETCH: if (run_s) begin
        c.bsrc = 3'd7; c.addr_ld = 1'b1; c.pc_inc = 1'b1; nxt = S_FWAIT;
      end
      S_FWAIT:  nxt = S_DECODE;
      S_DECODE: begin c.ir_ld = 1'b1; nxt = S_EXEC; end
      S_EXEC: begin
        unique case (op)
          OP_MV, OP_MVNZ: begin
            c.bsrc = ry; c.reg_we = (op == OP_MV) || g_nz;
            c.done = 1'b1; nxt = S_FETCH;
          end
          OP_MVI: begin
            c.bsrc = 3'd7; c.addr_ld = 1'b1; c.pc_inc = 1'b1; nxt = S_MEMW1;
          end
          OP_LD: begin c.bsrc = ry; c.addr_ld = 1'b1; nxt = S_MEMW1; end
          OP_ST: begin c.bsrc = ry; c.addr_ld = 1'b1; nxt = S_ST1; end
          OP_ADD, OP_SUB: begin c.bsrc = rx; c.a_ld = 1'b1; nxt = S_ALU1; end
          default: begin c.done = 1'b1; nxt = S_FETCH; end
        endcase
      end
      S_ALU1: begin
        c.bsrc = ry; c.g_ld = 1'b1; c.sub = (op == OP_SUB); nxt = S_ALU2;
      end
      S_ALU2: begin
        c.bsel = BUS_G; c.reg_we = 1'b1; c.done = 1'b1; nxt = S_FETCH;
      end
      S_MEMW1: nxt = S_MEMW2;
      S_MEMW2: begin
        c.bsel = BUS_DIN; c.reg_we = 1'b1; c.done = 1'b1; nxt = S_FETCH;
      end
      S_ST1: begin
        c.bsrc = rx; c.dout_ld = 1'b1; c.w_set = 1'b1; nxt = S_STW;
      end
      S_STW: begin c.done = 1'b1; nxt = S_FETCH; end
      default: nxt = S_FETCH;
    endcase
  end

  // R2: an idle boundary with run low completes nothing
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && !run_s) |=> !c.done);
endmodule

// File: rtl/mc_bus_cpu.sv
module mc_bus_cpu
  import cpu_pkg::*;
#(
  parameter int W        = 16,
  parameter int NREG     = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_async,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  output logic          instr_done
);
  localparam int AW = $clog2(NREG);

  ctrl_t        c;
  logic         run_s;
  logic [W-1:0] bus, rf_rdata, g_q;

  bus_run_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(run_async), .q_sync(run_s));

  bus_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_s(run_s), .din(mem_rdata),
    .g_nz(|g_q), .c(c));

  bus_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .we(c.reg_we),
    .dst(c.reg_dst[AW-1:0]), .pc_inc(c.pc_inc),
    .rsel(c.bsrc[AW-1:0]), .rdata(rf_rdata));

  bus_alu #(.W(W)) u_alu (
    .clk(clk), .rst_n(rst_n), .bus_in(bus), .a_ld(c.a_ld),
    .g_ld(c.g_ld), .sub(c.sub), .g_q(g_q));

  always_comb begin
    unique case (c.bsel)
      BUS_G:   bus = g_q;
      BUS_DIN: bus = mem_rdata;
      default: bus = rf_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      if (c.addr_ld) mem_addr  <= bus;
      if (c.dout_ld) mem_wdata <= bus;
      mem_we <= c.w_set;
    end
  end

  assign instr_done = c.done;

  // R7: write strobe lasts one cycle
  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R7: store address settled before the strobe
  assert_we_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_addr));
  // R10: completion is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);
  // R3: no strobe while a new instruction is being fetched
  assert_no_we_on_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c.ir_ld |-> !mem_we);
endmodule

// File: tb/mc_bus_cpu_bench.sv
module mc_bus_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 40;
  localparam int NEXP  = 8;

  function automatic logic [15:0] ins(int op, int x, int y);
    return {7'b0, op[2:0], x[2:0], y[2:0]};
  endfunction

  // opcodes: 0 mv 1 mvi 2 add 3 sub 4 ld 5 st 6 mvnz
  localparam logic [15:0] PROG [NPROG] = '{
    ins(1,0,0), 16'h0040, ins(1,1,0), 16'h1234, ins(5,1,0),
    ins(1,2,0), 16'h0001, ins(2,0,2), ins(1,3,0), 16'h00FF,
    ins(3,1,3), ins(5,1,0), ins(4,4,0), ins(2,0,2), ins(5,4,0),
    ins(1,5,0), 16'h0003, ins(0,6,7), ins(3,5,2), ins(6,7,6),
    ins(2,0,2), ins(5,5,0), ins(6,5,2), ins(2,0,2), ins(5,5,0),
    ins(3,5,2), ins(6,5,3), ins(2,0,2), ins(5,5,0), ins(1,7,0),
    16'd32,     ins(5,3,0), ins(2,0,2), ins(5,7,0), ins(1,6,0),
    16'd39,     ins(0,7,6), ins(5,3,0), ins(5,3,0), ins(0,7,6)
  };

  localparam logic [6:0]  EXP_ADDR [NEXP] = '{7'd64, 7'd65, 7'd66, 7'd67, 7'd68, 7'd69, 7'd70, 7'd71};
  localparam logic [15:0] EXP_VAL  [NEXP] = '{16'h1234, 16'h1135, 16'h1135, 16'h0000,
                                              16'h0001, 16'h0000, 16'd34, 16'hDEAD};
  localparam string EXP_REQ [NEXP] = '{"R4/R7", "R5", "R6", "R8", "R8", "R8", "R9", "R9"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_async = 1'b0;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_we, instr_done;

  int n_checks = 0, n_fail = 0;
  int we_cycles = 0, we_double = 0, done_cycles = 0, done_double = 0;
  logic we_prev = 1'b0, done_prev = 1'b0;

  logic [15:0] ram [128];
  logic [6:0]  ram_qa = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_bus_cpu u_mc_bus_cpu (
    .clk(clk), .rst_n(rst_n), .run_async(run_async), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .instr_done(instr_done));

  // synchronous RAM with registered inputs
  always @(posedge clk) begin
    ram_qa <= mem_addr[6:0];
    if (mem_we && mem_addr[15:12] == 4'h0) ram[mem_addr[6:0]] <= mem_wdata;
  end
  assign mem_rdata = ram[ram_qa];

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_we) we_cycles++;
      if (mem_we && we_prev) we_double++;
      if (instr_done) done_cycles++;
      if (instr_done && done_prev) done_double++;
    end
    we_prev   <= mem_we;
    done_prev <= instr_done;
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) ram[i] = 16'hDEAD;
    for (int i = 0; i < NPROG; i++) ram[i] = PROG[i];

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check(mem_addr == 16'h0, "R1 addr", mem_addr, 16'h0);
    check(mem_wdata == 16'h0, "R1 wdata", mem_wdata, 16'h0);
    check(mem_we == 1'b0, "R1 we", {15'b0, mem_we}, 16'h0);
    check(instr_done == 1'b0, "R1 done", {15'b0, instr_done}, 16'h0);

    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R2: run low keeps the processor idle
    check(done_cycles == 0, "R2 done count", 16'(done_cycles), 16'h0);
    check(we_cycles == 0, "R2 we count", 16'(we_cycles), 16'h0);
    check(mem_addr == 16'h0, "R2 addr hold", mem_addr, 16'h0);

    run_async = 1'b1;
    repeat (1500) @(negedge clk);

    // table walk: stored results, R4..R9
    for (int k = 0; k < NEXP; k++)
      check(ram[EXP_ADDR[k]] == EXP_VAL[k], EXP_REQ[k], ram[EXP_ADDR[k]], EXP_VAL[k]);

    // R7: seven stores, each one cycle
    check(we_cycles == 7, "R7 store count", 16'(we_cycles), 16'd7);
    check(we_double == 0, "R7 strobe width", 16'(we_double), 16'h0);
    // R10: done pulses, single cycle
    check(done_cycles > 40, "R10 done seen", 16'(done_cycles), 16'd41);
    check(done_double == 0, "R10 done width", 16'(done_double), 16'h0);
    // R9/R3: final jump-to-self loop fetches from 39
    check(mem_addr == 16'd39, "R9 loop addr", mem_addr, 16'd39);
    // R3: unused upper bits of ram were never written by a wrong address
    check(ram[0] == PROG[0], "R3 program intact", ram[0], PROG[0]);

    // R1: reset mid-run returns outputs to zero
    rst_n = 1'b0;
    @(negedge clk);
    check(mem_addr == 16'h0, "R1 mid-run addr", mem_addr, 16'h0);
    check(instr_done == 1'b0, "R1 mid-run done", {15'b0, instr_done}, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule